// File: doc/BRIEF.md
# Bit-Serial Receive Buffer with Serial Readout

This block holds received payload bits between a radio receiver's demodulator and the data-out line of an SPI slave. It stores up to 128 single bits in sixteen 8-bit lanes. Writing is idle until a frame-sync pulse arms it. After that, each data-clock strobe from the demodulator stores one bit at the write pointer. On the read side, the oldest unread bit is always presented on the serial output. Each read strobe, one per SPI shift clock, consumes that bit and moves on. Both pointers are up-counters that wrap. The host can therefore start draining right after frame sync and stream frames longer than the buffer, as long as it keeps pace with the writer.

A control state machine drives two more inputs. The first is a lock pulse, for example at end of message, which freezes the stored frame against further writes. The second is an initialise pulse, which returns pointers, contents, arming, lock and status to their empty state. The block reports the number of unread bits and a sticky overflow flag. In this block, all inputs are synchronous strobes in the `clk` domain.

Top module: `rx_bit_fifo`

## Requirements
- R1: After reset, `valid_cnt_o` is 0, `ovf_o` is 0 and `sdo_o` is 0.
- R2: Write strobes are ignored until a cycle after `fsync_i` has been high once since reset or the last initialise. A strobe in the same cycle as `fsync_i` is also ignored.
- R3: Once armed and unlocked, each `wr_stb_i` stores `wr_bit_i`. Bits leave on `sdo_o` in the order they were written, first written first out. Address a maps to lane a/8, bit a%8.
- R4: `valid_cnt_o` equals accepted writes minus accepted reads and never exceeds 128.
- R5: A write strobe that is otherwise accepted while 128 bits are unread is discarded. It sets `ovf_o`, which stays high until an initialise.
- R6: While bits are unread, `sdo_o` shows the oldest unread bit. A `rd_stb_i` consumes it, so the next bit appears after that clock edge.
- R7: While no bits are unread, `sdo_o` is 0 and `rd_stb_i` has no effect on the read pointer or the count.
- R8: A read and an accepted write in the same cycle leave `valid_cnt_o` unchanged. A stream of more than 128 bits passes without loss when reads keep pace.
- R9: A `lock_i` pulse blocks writes in its own cycle and in every later cycle until an initialise. Blocked strobes neither store bits nor set `ovf_o`.
- R10: An `init_i` pulse clears the count, the overflow flag, arming and lock on the next edge. Write and read strobes in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| init_i | input | 1 | Initialise pulse from the control state machine |
| fsync_i | input | 1 | Frame-sync pulse that arms writing |
| lock_i | input | 1 | Lock pulse that freezes the stored frame |
| wr_stb_i | input | 1 | Data-clock strobe from the demodulator |
| wr_bit_i | input | 1 | Received data bit |
| rd_stb_i | input | 1 | Read strobe, one per SPI shift clock |
| sdo_o | output | 1 | Oldest unread bit, 0 when empty |
| valid_cnt_o | output | 8 | Number of unread bits, 0 to 128 |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The hardest situation to reach is the read and write pointers both wrapping past address 127 while the buffer is partly full, with reads and writes landing in the same cycle. The bench arms the buffer, fills it to a partial level, and then streams a few hundred bits. Every cycle carries a write and, in most cycles, a read, so both pointers wrap several times. Each bit is compared against a model that computes the value from its sequence number. Separate sweeps cover writing to exactly 128 bits followed by extra strobes, draining to empty followed by extra reads, and locking mid-frame.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;

  localparam int unsigned LANE_BITS = 8;

  typedef struct packed {
    logic armed;
    logic locked;
    logic ovf;
  } ctl_flags_t;

  // one-hot select of a bit within an 8-bit lane
  function automatic logic [LANE_BITS-1:0] lane_decode(input logic [2:0] sel);
    logic [LANE_BITS-1:0] oh;
    oh = '0;
    oh[sel] = 1'b1;
    return oh;
  endfunction

endpackage

// File: rtl/rx_fifo_ptr.sv
module rx_fifo_ptr #(
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o
);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  assign ptr_en = clr_i | adv_i;

  always_comb begin
    ptr_d = ptr_q;
    if (clr_i) begin
      ptr_d = '0;
    end else if (adv_i) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/rx_fifo_mem.sv
module rx_fifo_mem
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic             wbit_i,
  output logic [DEPTH-1:0] bits_o
);

  localparam int unsigned NLANES = DEPTH / LANE_BITS;
  localparam int unsigned LAW    = AW - 3;

  logic [LANE_BITS-1:0] bit_sel;
  logic [NLANES-1:0]    lane_hit;

  assign bit_sel = lane_decode(waddr_i[2:0]);

  for (genvar b = 0; b < NLANES; b++) begin : g_lane
    assign lane_hit[b] = (waddr_i[AW-1:3] == LAW'(b));

    for (genvar k = 0; k < LANE_BITS; k++) begin : g_cell
      logic cell_q;
      logic cell_d;
      logic cell_en;

      assign cell_en = clr_i | (we_i & lane_hit[b] & bit_sel[k]);

      always_comb begin
        cell_d = cell_q;
        if (clr_i) begin
          cell_d = 1'b0;
        end else if (we_i) begin
          cell_d = wbit_i;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cell_q <= 1'b0;
        end else if (cell_en) begin
          cell_q <= cell_d;
        end
      end

      assign bits_o[b*LANE_BITS + k] = cell_q;
    end
  end

endmodule

// File: rtl/rx_fifo_rdmux.sv
module rx_fifo_rdmux
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] bits_i,
  input  logic [AW-1:0]    raddr_i,
  input  logic             empty_i,
  output logic             sdo_o
);

  localparam int unsigned NLANES = DEPTH / LANE_BITS;

  logic [LANE_BITS-1:0] lanes [NLANES];
  logic [LANE_BITS-1:0] cur_lane;

  for (genvar b = 0; b < NLANES; b++) begin : g_split
    assign lanes[b] = bits_i[b*LANE_BITS +: LANE_BITS];
  end

  // lane select, then 8-to-1 bit select
  always_comb begin
    cur_lane = lanes[raddr_i[AW-1:3]];
    sdo_o    = empty_i ? 1'b0 : cur_lane[raddr_i[2:0]];
  end

endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          fsync_i,
  input  logic          lock_i,
  input  logic          wr_stb_i,
  input  logic          rd_stb_i,
  output logic          wr_ok_o,
  output logic          rd_ok_o,
  output logic          empty_o,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  ctl_flags_t    flg_q;
  ctl_flags_t    flg_d;
  logic          full;
  logic          wr_take;
  logic          ovf_hit;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  always_comb begin
    wr_take = wr_stb_i & flg_q.armed & ~flg_q.locked & ~lock_i & ~init_i;
    wr_ok_o = wr_take & ~full;
    ovf_hit = wr_take & full;
    rd_ok_o = rd_stb_i & ~empty_o & ~init_i;
  end

  always_comb begin
    cnt_d = cnt_q;
    flg_d = flg_q;
    if (init_i) begin
      cnt_d = '0;
      flg_d = '0;
    end else begin
      case ({wr_ok_o, rd_ok_o})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
      flg_d.armed  = flg_q.armed  | fsync_i;
      flg_d.locked = flg_q.locked | lock_i;
      flg_d.ovf    = flg_q.ovf    | ovf_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flg_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      flg_q <= flg_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = flg_q.ovf;

endmodule

// File: rtl/rx_bit_fifo.sv
module rx_bit_fifo #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          fsync_i,
  input  logic          lock_i,
  input  logic          wr_stb_i,
  input  logic          wr_bit_i,
  input  logic          rd_stb_i,
  output logic          sdo_o,
  output logic [CW-1:0] valid_cnt_o,
  output logic          ovf_o
);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             wr_ok;
  logic             rd_ok;
  logic             empty;
  logic [AW-1:0]    wptr;
  logic [AW-1:0]    rptr;
  logic [DEPTH-1:0] store;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  rx_fifo_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .init_i   (init_i),
    .fsync_i  (fsync_i),
    .lock_i   (lock_i),
    .wr_stb_i (wr_stb_i),
    .rd_stb_i (rd_stb_i),
    .wr_ok_o  (wr_ok),
    .rd_ok_o  (rd_ok),
    .empty_o  (empty),
    .cnt_o    (valid_cnt_o),
    .ovf_o    (ovf_o)
  );

  rx_fifo_ptr #(.AW(AW)) u_wptr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (init_i),
    .adv_i (wr_ok),
    .ptr_o (wptr)
  );

  rx_fifo_ptr #(.AW(AW)) u_rptr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (init_i),
    .adv_i (rd_ok),
    .ptr_o (rptr)
  );

  rx_fifo_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (init_i),
    .we_i    (wr_ok),
    .waddr_i (wptr),
    .wbit_i  (wr_bit_i),
    .bits_o  (store)
  );

  rx_fifo_rdmux #(.DEPTH(DEPTH), .AW(AW)) u_rdmux (
    .bits_i  (store),
    .raddr_i (rptr),
    .empty_i (empty),
    .sdo_o   (sdo_o)
  );

endmodule

// File: rtl/rx_bit_fifo_chk.sv
module rx_bit_fifo_chk #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          init_i,
  input logic          fsync_i,
  input logic          lock_i,
  input logic          wr_stb_i,
  input logic          rd_stb_i,
  input logic          sdo_o,
  input logic [CW-1:0] valid_cnt_o,
  input logic          ovf_o
);

  logic seen_sync_q;
  logic seen_lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_sync_q <= 1'b0;
      seen_lock_q <= 1'b0;
    end else if (init_i) begin
      seen_sync_q <= 1'b0;
      seen_lock_q <= 1'b0;
    end else begin
      seen_sync_q <= seen_sync_q | fsync_i;
      seen_lock_q <= seen_lock_q | lock_i;
    end
  end

  // R4
  cnt_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_cnt_o <= CW'(DEPTH));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !init_i) |=> ovf_o);

  // R7
  empty_sdo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_cnt_o == '0) |-> !sdo_o);

  // R10
  init_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (valid_cnt_o == '0) && !ovf_o);

  // R2
  unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_sync_q |=> valid_cnt_o <= $past(valid_cnt_o));

  // R9
  locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_lock_q || lock_i) |=> valid_cnt_o <= $past(valid_cnt_o));

  // R8
  rw_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_i && rd_stb_i && seen_sync_q && !seen_lock_q && !lock_i && !init_i
     && valid_cnt_o != '0 && valid_cnt_o != CW'(DEPTH))
    |=> valid_cnt_o == $past(valid_cnt_o));

endmodule

bind rx_bit_fifo rx_bit_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .init_i      (init_i),
  .fsync_i     (fsync_i),
  .lock_i      (lock_i),
  .wr_stb_i    (wr_stb_i),
  .rd_stb_i    (rd_stb_i),
  .sdo_o       (sdo_o),
  .valid_cnt_o (valid_cnt_o),
  .ovf_o       (ovf_o)
);

// File: tb/rx_bit_fifo_tb.sv
module rx_bit_fifo_tb;

  localparam int DEPTH = 128;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       init_i, fsync_i, lock_i, wr_stb_i, wr_bit_i, rd_stb_i;
  logic       sdo_o;
  logic [7:0] valid_cnt_o;
  logic       ovf_o;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  // reference state
  bit m_mem [DEPTH];
  int m_wp, m_rp, m_cnt;
  bit m_armed, m_locked, m_ovf;

  always #4 clk = ~clk;

  rx_bit_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk, .rst_n, .init_i, .fsync_i, .lock_i, .wr_stb_i, .wr_bit_i,
    .rd_stb_i, .sdo_o, .valid_cnt_o, .ovf_o
  );

  function automatic bit pat(input int n);
    return bit'(((n * 13) >> 2) ^ n ^ (n >> 5));
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "count", int'(valid_cnt_o), m_cnt);
    chk(req, "ovf", int'(ovf_o), int'(m_ovf));
    chk(req, "sdo", int'(sdo_o), (m_cnt > 0) ? int'(m_mem[m_rp]) : 0);
  endtask

  // one clock: drive at a falling edge, update model, check at the next falling edge
  task automatic cyc(input bit ini, input bit fs, input bit lk, input bit wr,
                     input bit wb, input bit rd, input string req);
    bit take, wok, rok;
    init_i = ini; fsync_i = fs; lock_i = lk; wr_stb_i = wr; wr_bit_i = wb; rd_stb_i = rd;
    @(negedge clk);
    if (ini) begin
      m_wp = 0; m_rp = 0; m_cnt = 0;
      m_armed = 0; m_locked = 0; m_ovf = 0;
    end else begin
      take = wr && m_armed && !m_locked && !lk;
      wok  = take && (m_cnt < DEPTH);
      rok  = rd && (m_cnt > 0);
      if (take && m_cnt == DEPTH) m_ovf = 1;
      if (wok) begin m_mem[m_wp] = wb; m_wp = (m_wp + 1) % DEPTH; end
      if (rok) m_rp = (m_rp + 1) % DEPTH;
      m_cnt = m_cnt + int'(wok) - int'(rok);
      m_armed  = m_armed  | fs;
      m_locked = m_locked | lk;
    end
    init_i = 0; fsync_i = 0; lock_i = 0; wr_stb_i = 0; wr_bit_i = 0; rd_stb_i = 0;
    check_all(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int seq;
    rst_n = 0;
    init_i = 0; fsync_i = 0; lock_i = 0; wr_stb_i = 0; wr_bit_i = 0; rd_stb_i = 0;
    m_wp = 0; m_rp = 0; m_cnt = 0; m_armed = 0; m_locked = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R2: strobes before arming, and in the arming cycle, are ignored
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 1, pat(i), 0, "R2");
    cyc(0, 1, 0, 1, 1, 0, "R2");

    // R3 R4: fill to exactly 128
    seq = 0;
    for (int i = 0; i < DEPTH; i++) begin cyc(0, 0, 0, 1, pat(seq), 0, "R3"); seq++; end
    chk("R4", "full count", int'(valid_cnt_o), DEPTH);
    // R5: extra strobes discarded, flag set and sticky
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 1, 0, "R5");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0, "R5");
    // R6: drain in order
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 0, 0, 1, "R6");
    // R7: reads on empty do nothing, then a new bit is the first out
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 1, "R7");
    cyc(0, 0, 0, 1, 1, 0, "R7");
    cyc(0, 0, 0, 0, 0, 1, "R7");

    // R10: init with strobes in the same cycle
    cyc(1, 0, 0, 1, 1, 1, "R10");
    chk("R10", "ovf cleared", int'(ovf_o), 0);
    cyc(0, 0, 0, 1, 1, 0, "R10");

    // R8: partial fill, then long streaming with wrap
    cyc(0, 1, 0, 0, 0, 0, "R8");
    seq = 0;
    for (int i = 0; i < 50; i++) begin cyc(0, 0, 0, 1, pat(seq), 0, "R8"); seq++; end
    for (int i = 0; i < 400; i++) begin
      cyc(0, 0, 0, 1, pat(seq), (i % 7) != 3, "R8"); seq++;
    end
    for (int i = 0; i < 200; i++) cyc(0, 0, 0, 0, 0, 1, "R8");

    // R9: lock mid-frame, including a strobe in the lock cycle
    cyc(1, 0, 0, 0, 0, 0, "R10");
    cyc(0, 1, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 1, pat(i + 3), 0, "R9");
    cyc(0, 0, 1, 1, 1, 0, "R9");
    for (int i = 0; i < 140; i++) cyc(0, 0, 0, 1, 1, 0, "R9");
    chk("R9", "locked count", int'(valid_cnt_o), 10);
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, 0, 0, 1, "R9");

    // R2 again: re-arming needed after init
    cyc(1, 0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 1, 0, "R2");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule